// File: doc/BRIEF.md
# Codebook Slice Sequencer

This controller steps one codebook sub-block of a vector quantizer through a nearest-neighbour search and the optional weight update that follows it. Each codebook entry is held as `m` consecutive slices. A slice is one row of 16 lanes, so `m` is the vector length divided by 16, rounded up. Software can change the compression ratio between operations by changing `m`. The controller produces the codebook read addresses. It also produces a flag that marks the last slice of every vector, so the distance adder downstream knows where one vector ends and the next begins.

A pulse on `start_i` begins an operation. The controller then sweeps every slice of every neuron in the sub-block, one slice per cycle. It then waits out the search pipeline. If learning was requested, it switches the datapath to update mode and reads the winner's slices from the winner's start address. For each slice it issues a write-back a fixed number of cycles after the read. A one-cycle `done_o` pulse marks the end of the operation. The datapath and the memory contents are outside this block.

Top module: `vq_slice_sequencer`

## Requirements
- R1: While `rst_ni` is low, every output is 0: `rd_en_o`, `rd_addr_o`, `sep_o`, `mode_sel_o`, `wr_en_o`, `wr_addr_o` and `done_o`.
- R2: A `start_i` seen at a clock edge while the block is idle begins the search phase in the next cycle. The block reads addresses 0 up to m·n−1, one per cycle, with `rd_en_o`=1 and `mode_sel_o`=0. Here m is the value of `slices_i` and n the value of `neurons_i`, both taken at that edge.
- R3: `sep_o` is 1 exactly in the read cycles that carry the m-th slice of a vector. During the search these are the addresses a with (a+1) mod m = 0. It is never 1 without `rd_en_o`.
- R4: In search-only mode (`learn_i`=0 at start), `done_o` is 1 in the cycle with index m·n+7, counting the first read cycle as index 0. No read happens between the last search read and `done_o`, and none after it.
- R5: In learning mode (`learn_i`=1), `mode_sel_o` goes to 1 in cycle m·n+7. From that cycle the block reads m consecutive addresses, starting at the `winner_addr_i` value present in the cycle before. `sep_o` is 1 on the last of these reads.
- R6: Each learning read is followed by exactly one `wr_en_o` pulse, UPD_LAT (default 3) cycles later, with `wr_addr_o` equal to that read's address. `wr_en_o` is never 1 during the search phase.
- R7: In learning mode `mode_sel_o` stays 1 up to and including the last write-back cycle, m·n+7+m−1+UPD_LAT. `done_o` is 1 in the cycle after it, with `mode_sel_o` back at 0.
- R8: Changes to `slices_i`, `neurons_i` or `learn_i` after the start edge have no effect, and `start_i` is ignored while an operation runs.
- R9: A `slices_i` or `neurons_i` value of 0 is treated as 1.
- R10: `done_o` is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| learn_i | input | 1 | 1: search then update the winner; 0: search only |
| slices_i | input | M_W (4) | Slices per vector, m |
| neurons_i | input | N_W (7) | Neurons in this sub-block, n |
| winner_addr_i | input | ADDR_W (10) | Start address of the winning vector |
| rd_en_o | output | 1 | Codebook read strobe |
| rd_addr_o | output | ADDR_W (10) | Codebook read address |
| sep_o | output | 1 | Last slice of a vector on this read |
| mode_sel_o | output | 1 | Datapath mode: 0 distance, 1 weight update |
| wr_en_o | output | 1 | Codebook write strobe for an updated slice |
| wr_addr_o | output | ADDR_W (10) | Codebook write address |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
Several properties are checked on every clock cycle. The separation flag only appears on a read, and consecutive slices of a vector have consecutive addresses. Every write trails a learning read by the update latency, at the same address. The first update read lands on the sampled winner address, and done lasts one cycle. Other behaviour depends on absolute timing over a whole operation, and only the bench's scenarios show it. That covers the cycle index of done for each m and n, the exact cycles in which the flag appears, the ignoring of late input changes and of a repeated start, and the clamping of zero counts. For those, the bench compares a per-cycle expected trace against the outputs.

// File: rtl/vq_seq_pkg.sv
package vq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENC,
    ST_DRAIN,
    ST_LEARN,
    ST_FLUSH
  } seq_state_e;
endpackage

// File: rtl/vq_slice_ctr.sv
module vq_slice_ctr #(
  parameter int M_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           step_i,
  input  logic [M_W-1:0] m_i,
  output logic           last_o
);
  logic [M_W-1:0] cnt_q;

  assign last_o = (cnt_q == m_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= M_W'(1);
    else if (clear_i) cnt_q <= M_W'(1);
    else if (step_i)  cnt_q <= last_o ? M_W'(1) : cnt_q + M_W'(1);
  end

  AST_SLICE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q >= M_W'(1)) && (cnt_q <= m_i)); // R3
endmodule

// File: rtl/vq_wr_pipe.sv
module vq_wr_pipe #(
  parameter int ADDR_W = 10,
  parameter int LAT    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [LAT-1:0]    vld_sr;
  logic [ADDR_W-1:0] addr_sr [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_sr[0]  <= 1'b0;
      addr_sr[0] <= '0;
    end else begin
      vld_sr[0]  <= vld_i;
      addr_sr[0] <= addr_i;
    end
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_sr[g]  <= 1'b0;
        addr_sr[g] <= '0;
      end else begin
        vld_sr[g]  <= vld_sr[g-1];
        addr_sr[g] <= addr_sr[g-1];
      end
    end
  end

  assign vld_o  = vld_sr[LAT-1];
  assign addr_o = vld_sr[LAT-1] ? addr_sr[LAT-1] : '0;
endmodule

// File: rtl/vq_slice_sequencer.sv
module vq_slice_sequencer
  import vq_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int M_W        = 4,
  parameter int N_W        = 7,
  parameter int SEARCH_LAT = 7,
  parameter int UPD_LAT    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              learn_i,
  input  logic [M_W-1:0]    slices_i,
  input  logic [N_W-1:0]    neurons_i,
  input  logic [ADDR_W-1:0] winner_addr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sep_o,
  output logic              mode_sel_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              done_o
);
  localparam int WAIT_MAX = (SEARCH_LAT > UPD_LAT) ? SEARCH_LAT : UPD_LAT;
  localparam int W_W      = $clog2(WAIT_MAX + 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [N_W-1:0]    nidx_q, n_q;
  logic [M_W-1:0]    m_q;
  logic [W_W-1:0]    wait_q;
  logic              learn_q, done_q;
  logic              slice_last, slice_clear, slice_step;
  logic              go, drain_end, flush_end;

  assign go          = (state_q == ST_IDLE) && start_i;
  assign drain_end   = (state_q == ST_DRAIN) && (wait_q == W_W'(SEARCH_LAT - 1));
  assign flush_end   = (state_q == ST_FLUSH) && (wait_q == W_W'(UPD_LAT - 1));
  assign slice_step  = (state_q == ST_ENC) || (state_q == ST_LEARN);
  assign slice_clear = go || (drain_end && learn_q);

  vq_slice_ctr #(.M_W(M_W)) u_slice (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (slice_clear),
    .step_i  (slice_step),
    .m_i     (m_q),
    .last_o  (slice_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      nidx_q  <= '0;
      n_q     <= N_W'(1);
      m_q     <= M_W'(1);
      wait_q  <= '0;
      learn_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          m_q     <= (slices_i == '0) ? M_W'(1) : slices_i;
          n_q     <= (neurons_i == '0) ? N_W'(1) : neurons_i;
          learn_q <= learn_i;
          addr_q  <= '0;
          nidx_q  <= '0;
          state_q <= ST_ENC;
        end
        ST_ENC: begin
          addr_q <= addr_q + ADDR_W'(1);
          if (slice_last) begin
            nidx_q <= nidx_q + N_W'(1);
            if (nidx_q == n_q - N_W'(1)) begin
              wait_q  <= '0;
              state_q <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          wait_q <= wait_q + W_W'(1);
          if (drain_end) begin
            if (learn_q) begin
              addr_q  <= winner_addr_i;
              state_q <= ST_LEARN;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_LEARN: begin
          addr_q <= addr_q + ADDR_W'(1);
          if (slice_last) begin
            wait_q  <= '0;
            state_q <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          wait_q <= wait_q + W_W'(1);
          if (flush_end) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en_o    = slice_step;
  assign rd_addr_o  = slice_step ? addr_q : '0;
  assign sep_o      = slice_step && slice_last;
  assign mode_sel_o = (state_q == ST_LEARN) || (state_q == ST_FLUSH);
  assign done_o     = done_q;

  vq_wr_pipe #(.ADDR_W(ADDR_W), .LAT(UPD_LAT)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (state_q == ST_LEARN),
    .addr_i (addr_q),
    .vld_o  (wr_en_o),
    .addr_o (wr_addr_o)
  );

  AST_SEP_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sep_o |-> rd_en_o); // R3
  AST_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && !sep_o) |=> rd_en_o && ((rd_addr_o - $past(rd_addr_o)) == ADDR_W'(1))); // R2
  AST_WINNER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_sel_o) |-> rd_en_o && (rd_addr_o == $past(winner_addr_i))); // R5
  AST_WR_TRAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rd_en_o && mode_sel_o, UPD_LAT)); // R6
  AST_WR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o == $past(rd_addr_o, UPD_LAT))); // R6
  AST_WR_IN_LEARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> mode_sel_o); // R6
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_en_o && !mode_sel_o && !wr_en_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

// File: tb/sim_vq_slice_sequencer.sv
module sim_vq_slice_sequencer;
  localparam int UL   = 3;
  localparam int SL   = 7;
  localparam int MAXC = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, learn = 1'b0;
  logic [3:0] slices = '0;
  logic [6:0] neurons = '0;
  logic [9:0] winner = '0;
  logic       rd_en, sep, mode_sel, wr_en, done;
  logic [9:0] rd_addr, wr_addr;

  int n_cmp = 0;
  int n_bad = 0;

  bit e_rd [MAXC];
  int e_ra [MAXC];
  bit e_sep[MAXC];
  bit e_md [MAXC];
  bit e_wr [MAXC];
  int e_wa [MAXC];
  bit e_dn [MAXC];

  always #10 clk = ~clk;

  vq_slice_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .learn_i(learn),
    .slices_i(slices), .neurons_i(neurons), .winner_addr_i(winner),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .sep_o(sep), .mode_sel_o(mode_sel),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .done_o(done)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Per-cycle reference trace built from the requirements, then compared.
  task automatic run_op(int m, int n, bit lrn, int w, bit disturb, string tag);
    int me, ne, len, base;
    me = (m == 0) ? 1 : m;
    ne = (n == 0) ? 1 : n;
    base = me * ne + SL;
    len = lrn ? base + me + UL + 1 : base + 1;
    for (int i = 0; i < len + 3; i++) begin
      e_rd[i] = 0; e_ra[i] = 0; e_sep[i] = 0; e_md[i] = 0;
      e_wr[i] = 0; e_wa[i] = 0; e_dn[i] = 0;
    end
    for (int i = 0; i < me * ne; i++) begin
      e_rd[i] = 1; e_ra[i] = i; e_sep[i] = ((i % me) == me - 1);
    end
    if (lrn) begin
      for (int j = 0; j < me; j++) begin
        e_rd[base + j] = 1;
        e_ra[base + j] = (w + j) % 1024;
        e_sep[base + j] = (j == me - 1);
        e_wr[base + j + UL] = 1;
        e_wa[base + j + UL] = (w + j) % 1024;
      end
      for (int i = base; i < base + me + UL; i++) e_md[i] = 1;
    end
    e_dn[len - 1] = 1;

    @(negedge clk);
    start = 1; learn = lrn; slices = 4'(m); neurons = 7'(n); winner = 10'(w);
    @(negedge clk);
    if (disturb) begin
      slices = 4'd7; neurons = 7'd9; learn = ~lrn;  // R8 late changes
    end else start = 0;
    for (int c = 0; c < len + 3; c++) begin
      chk($sformatf("%s R2 rd_en c%0d", tag, c), rd_en, e_rd[c]);
      if (e_rd[c]) chk($sformatf("%s R2 rd_addr c%0d", tag, c), rd_addr, e_ra[c]);
      chk($sformatf("%s R3 sep c%0d", tag, c), sep, e_sep[c]);
      chk($sformatf("%s R5 mode_sel c%0d", tag, c), mode_sel, e_md[c]);
      chk($sformatf("%s R6 wr_en c%0d", tag, c), wr_en, e_wr[c]);
      if (e_wr[c]) chk($sformatf("%s R6 wr_addr c%0d", tag, c), wr_addr, e_wa[c]);
      chk($sformatf("%s %s R10 done c%0d", tag, lrn ? "R7" : "R4", c), done, e_dn[c]);
      if (disturb && c == 2) start = 0;  // R8 start held while busy
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_en", rd_en, 0);
    chk("R1 rd_addr", rd_addr, 0);
    chk("R1 sep", sep, 0);
    chk("R1 mode_sel", mode_sel, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    run_op(2, 3, 0, 0, 0, "enc_m2");
    run_op(1, 4, 0, 0, 0, "enc_m1");
    run_op(15, 5, 0, 0, 0, "enc_m15");
    run_op(3, 4, 1, 17, 0, "lrn_m3");
    run_op(5, 6, 1, 100, 0, "lrn_m5");
    run_op(4, 2, 1, 40, 1, "R8_disturb");
    run_op(0, 0, 1, 5, 0, "R9_zero");
    run_op(0, 3, 0, 0, 0, "R9_zero_m");
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end
endmodule